// File: doc/BRIEF.md
# Log-Domain Complex Gain Control Loop

This block applies an adaptive gain to a stream of complex samples (I and Q). The gain is tracked in the log2 domain. An external averager, which is not part of this block, delivers one averaged power value per update, marked by a strobe. At each update the block takes log2 of that power and halves it to get an rms level. It subtracts the rms level from a programmable request level, and passes the difference through a second-order loop filter. The filter output is a log-domain gain. A power-of-two converter turns it into a mantissa and a right-shift amount.

Every valid sample is multiplied by the linear gain, then saturated symmetrically to a programmable output width. The block also exports a measurement signal for the external averager. In level mode this signal is the scaled sample before saturation. In clipping mode it is the part of the scaled sample that the saturation removed. In bypass the gain is pinned to a programmed log value, and scaling and saturation still apply.

Top module: `agc_log_loop`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` is 0 and `gain_log` is 0.
- R2: The power value's log is floor(log2) in the integer part, plus the 8 bits below the leading one as the fraction. A power of 0 maps to 0. The error is `cfg_req` minus half that log (shift right by one), both unsigned with 8 fraction bits.
- R3: On each `pwr_stb` with bypass off, the step is d = (P·d_prev + K·e_prev) >>> 8, using arithmetic shift. Here e_prev is the error from the previous strobe, and P and K are unsigned with 8 fraction bits. Then the gain becomes gain + d. The first strobe after reset therefore leaves the gain unchanged.
- R4: With no strobe and bypass off, `gain_log` holds its value.
- R5: The gain update saturates to the signed 12-bit range: -2048 (factor 1/256) up to 2047 (just under 256).
- R6: One cycle after `in_valid`, `out_valid` rises. The outputs are then clip((x·m) >>> (8 − g_int)), computed with the gain held before that clock edge. Here g_int = gain >>> 8, and m = round(256·2^(f/16)), where f is gain bits 7:4.
- R7: Saturation is symmetric to ±(2^(w−1)−1). The width w is `cfg_out_w`, forced into the range 2..16.
- R8: With `cfg_mode`=0, `meas_i`/`meas_q` carry the scaled value before saturation.
- R9: With `cfg_mode`=1, `meas_i`/`meas_q` carry the value before saturation minus the value after it.
- R10: With `cfg_bypass`=1, `gain_log` equals `cfg_fix_gain` from the next cycle on. Strobes are ignored, and the filter step and stored error are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_bypass | input | 1 | Pin gain to the fixed value |
| cfg_mode | input | 1 | 0 = signal-level measurement, 1 = clipping residue |
| cfg_fix_gain | input | 12 | Fixed log2 gain used in bypass, signed, 8 fraction bits |
| cfg_req | input | 13 | Requested log2 rms level, 8 fraction bits |
| cfg_k | input | 12 | Loop gain K, 8 fraction bits |
| cfg_p | input | 8 | Loop pole P, 8 fraction bits |
| cfg_out_w | input | 5 | Output width in bits (2..16) |
| pwr_stb | input | 1 | Averaged power value valid |
| pwr_val | input | 32 | Averaged power |
| in_valid | input | 1 | Input sample valid |
| in_i | input | 16 | Input I, signed |
| in_q | input | 16 | Input Q, signed |
| out_valid | output | 1 | Output sample valid |
| out_i | output | 16 | Scaled and saturated I |
| out_q | output | 16 | Scaled and saturated Q |
| meas_i | output | 26 | Measurement I for the averager |
| meas_q | output | 26 | Measurement Q for the averager |
| gain_log | output | 12 | Current log2 gain, signed, 8 fraction bits |

## Verification
A gain update and a sample multiplication can land on the same clock edge. The sample must be scaled with the gain that existed before the edge, and the new gain takes effect only from the next sample. The bench raises `pwr_stb` and `in_valid` in the same cycle. Its scoreboard computes the expected product with the old gain and then applies the model update, so a design that forwards the new gain fails the compare. Saturation and residue output also share that cycle, and are judged against the model's pre-clip and post-clip values.

// File: rtl/agc_pkg.sv
// Shared sizing for the log-domain gain loop.
// Assumes FRAC_W >= LUT_BITS and PWR_W - 1 >= FRAC_W.
package agc_pkg;
    parameter int IN_W     = 16;  // sample width
    parameter int PWR_W    = 32;  // averaged power width
    parameter int FRAC_W   = 8;   // fraction bits of all log values and coefficients
    parameter int GINT_W   = 4;   // integer bits of the log gain (signed)
    parameter int K_W      = 12;  // loop gain width
    parameter int P_W      = 8;   // loop pole width (pure fraction)
    parameter int OUTW_W   = 5;   // width of the output-width field
    parameter int D_W      = 32;  // loop filter step register width
    parameter int LUT_BITS = 4;   // fraction bits resolved by the 2^x table
    parameter int LANES    = 2;   // I and Q

    localparam int IDX_W  = $clog2(PWR_W);
    localparam int LOG_W  = IDX_W + FRAC_W;
    localparam int G_W    = GINT_W + FRAC_W;
    localparam int ERR_W  = LOG_W + 1;
    localparam int MANT_W = FRAC_W + 1;
    localparam int PRE_W  = IN_W + MANT_W + 1;
    localparam int SH_W   = $clog2(FRAC_W + (1 << (GINT_W - 1)) + 1);
    localparam int ACC_W  = D_W + K_W + 2;
endpackage

// File: rtl/agc_log2.sv
// Piecewise-linear log2 of an unsigned power value.
// Integer part = index of the leading one; fraction = the FRAC_W bits after it.
// Purely combinational; zero input yields zero.
module agc_log2
    import agc_pkg::*;
(
    input  logic [PWR_W-1:0] pwr,
    output logic [LOG_W-1:0] logv
);
    logic [IDX_W-1:0]  msb;
    logic [PWR_W-1:0]  norm;
    logic [FRAC_W-1:0] frac;

    // Leading-one search, then normalise so the leading one sits at the top.
    always_comb begin
        msb = '0;
        for (int b = 0; b < PWR_W; b++) begin
            if (pwr[b]) msb = IDX_W'(b);
        end
        norm = pwr << (IDX_W'(PWR_W - 1) - msb);
        frac = FRAC_W'(norm >> (PWR_W - 1 - FRAC_W));
        logv = (pwr == '0) ? '0 : {msb, frac};
    end
endmodule

// File: rtl/agc_loop_filter.sv
// Error forming and two-pole loop filter in the log domain.
// y[n] = y[n-1] + d[n], d[n] = (P*d[n-1] + K*e[n-1]) >>> FRAC_W, with
// e = request - log/2. State moves only on a strobe; bypass pins y to the
// fixed gain and clears d and e. Assumes d stays inside D_W bits.
module agc_loop_filter
    import agc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bypass,
    input  logic signed [G_W-1:0]   fix_gain,
    input  logic [LOG_W-1:0]        req,
    input  logic [K_W-1:0]          k,
    input  logic [P_W-1:0]          p,
    input  logic                    stb,
    input  logic [LOG_W-1:0]        logv,
    output logic signed [G_W-1:0]   gain
);
    localparam logic signed [D_W:0] Y_HI = (D_W+1)'((64'sd1 <<< (G_W - 1)) - 64'sd1);
    localparam logic signed [D_W:0] Y_LO = -Y_HI - (D_W+1)'(1);

    logic [LOG_W-1:0]          rms;
    logic signed [ERR_W-1:0]   err;
    logic signed [ERR_W-1:0]   e_q;
    logic signed [D_W-1:0]     d_q, d_nx;
    logic signed [ACC_W-1:0]   p_ext, d_ext, k_ext, e_ext, acc;
    logic signed [D_W:0]       y_sum;
    logic signed [G_W-1:0]     y_nx;

    // Error: request minus rms, the rms being half the log power.
    always_comb begin
        rms = logv >> 1;
        err = $signed({1'b0, req}) - $signed({1'b0, rms});
    end

    // Second-order recursion and saturation of the new gain.
    always_comb begin
        p_ext = ACC_W'($signed({1'b0, p}));
        k_ext = ACC_W'($signed({1'b0, k}));
        d_ext = ACC_W'(d_q);
        e_ext = ACC_W'(e_q);
        acc   = p_ext * d_ext + k_ext * e_ext;
        d_nx  = D_W'(acc >>> FRAC_W);
        y_sum = (D_W+1)'(gain) + (D_W+1)'(d_nx);
        if (y_sum > Y_HI)      y_nx = G_W'(Y_HI);
        else if (y_sum < Y_LO) y_nx = G_W'(Y_LO);
        else                   y_nx = G_W'(y_sum);
    end

    // Filter state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain <= '0;
            d_q  <= '0;
            e_q  <= '0;
        end else if (bypass) begin
            gain <= fix_gain;
            d_q  <= '0;
            e_q  <= '0;
        end else if (stb) begin
            gain <= y_nx;
            d_q  <= d_nx;
            e_q  <= err;
        end
    end
endmodule

// File: rtl/agc_exp2.sv
// Log-to-linear conversion: 2^gain = mant/2^FRAC_W * 2^g_int.
// The caller applies it as (x*mant) >>> (FRAC_W - g_int). The mantissa table
// covers 2^LUT_BITS steps of the fraction (16 entries with the defaults).
module agc_exp2
    import agc_pkg::*;
(
    input  logic signed [G_W-1:0] gain,
    output logic [MANT_W-1:0]     mant,
    output logic [SH_W-1:0]       shamt
);
    logic signed [GINT_W-1:0] g_int;
    logic [LUT_BITS-1:0]      idx;

    // Split gain into integer shift and table index.
    always_comb begin
        g_int = GINT_W'(gain >>> FRAC_W);
        idx   = LUT_BITS'(gain >> (FRAC_W - LUT_BITS));
        shamt = SH_W'(FRAC_W) - SH_W'(g_int);
    end

    // Mantissa table: round(256 * 2^(idx/16)).
    always_comb begin
        case (idx)
            4'd0:    mant = MANT_W'(256);
            4'd1:    mant = MANT_W'(267);
            4'd2:    mant = MANT_W'(279);
            4'd3:    mant = MANT_W'(292);
            4'd4:    mant = MANT_W'(304);
            4'd5:    mant = MANT_W'(318);
            4'd6:    mant = MANT_W'(332);
            4'd7:    mant = MANT_W'(347);
            4'd8:    mant = MANT_W'(362);
            4'd9:    mant = MANT_W'(378);
            4'd10:   mant = MANT_W'(395);
            4'd11:   mant = MANT_W'(412);
            4'd12:   mant = MANT_W'(431);
            4'd13:   mant = MANT_W'(450);
            4'd14:   mant = MANT_W'(470);
            default: mant = MANT_W'(490);
        endcase
    end
endmodule

// File: rtl/agc_scaler.sv
// One lane: multiply by the linear gain, saturate symmetrically to +-lim,
// and form the measurement (pre-clip value, or the residue cut by clipping).
// Combinational; lim is assumed positive and below 2^(IN_W-1).
module agc_scaler
    import agc_pkg::*;
(
    input  logic signed [IN_W-1:0]  x,
    input  logic [MANT_W-1:0]       mant,
    input  logic [SH_W-1:0]         shamt,
    input  logic signed [PRE_W-1:0] lim,
    input  logic                    mode,
    output logic signed [IN_W-1:0]  post,
    output logic signed [PRE_W-1:0] meas
);
    logic signed [PRE_W-1:0] x_ext, m_ext, prod, pre, clipped;

    // Scale, saturate and select the measurement source.
    always_comb begin
        x_ext = PRE_W'(x);
        m_ext = PRE_W'($signed({1'b0, mant}));
        prod  = x_ext * m_ext;
        pre   = prod >>> shamt;
        if (pre > lim)       clipped = lim;
        else if (pre < -lim) clipped = -lim;
        else                 clipped = pre;
        post = IN_W'(clipped);
        meas = mode ? (pre - clipped) : pre;
    end
endmodule

// File: rtl/agc_log_loop.sv
// Top of the log-domain complex gain loop. Power values arrive on a strobe
// from an external averager; samples are scaled with the gain held before
// the clock edge and registered once. Configuration is assumed quasi-static.
module agc_log_loop
    import agc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_bypass,
    input  logic                    cfg_mode,
    input  logic signed [G_W-1:0]   cfg_fix_gain,
    input  logic [LOG_W-1:0]        cfg_req,
    input  logic [K_W-1:0]          cfg_k,
    input  logic [P_W-1:0]          cfg_p,
    input  logic [OUTW_W-1:0]       cfg_out_w,
    input  logic                    pwr_stb,
    input  logic [PWR_W-1:0]        pwr_val,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_i,
    input  logic signed [IN_W-1:0]  in_q,
    output logic                    out_valid,
    output logic signed [IN_W-1:0]  out_i,
    output logic signed [IN_W-1:0]  out_q,
    output logic signed [PRE_W-1:0] meas_i,
    output logic signed [PRE_W-1:0] meas_q,
    output logic signed [G_W-1:0]   gain_log
);
    logic [LOG_W-1:0]        logv;
    logic [MANT_W-1:0]       mant;
    logic [SH_W-1:0]         shamt;
    logic [OUTW_W-1:0]       eff_w;
    logic signed [PRE_W-1:0] lim;
    logic signed [IN_W-1:0]  lane_x    [LANES];
    logic signed [IN_W-1:0]  lane_post [LANES];
    logic signed [PRE_W-1:0] lane_meas [LANES];

    agc_log2 u_log (.pwr(pwr_val), .logv(logv));

    agc_loop_filter u_filt (
        .clk(clk), .rst_n(rst_n), .bypass(cfg_bypass), .fix_gain(cfg_fix_gain),
        .req(cfg_req), .k(cfg_k), .p(cfg_p), .stb(pwr_stb), .logv(logv),
        .gain(gain_log)
    );

    agc_exp2 u_exp (.gain(gain_log), .mant(mant), .shamt(shamt));

    // Force the output width into 2..IN_W and derive the saturation limit.
    always_comb begin
        if (cfg_out_w < OUTW_W'(2))          eff_w = OUTW_W'(2);
        else if (cfg_out_w > OUTW_W'(IN_W))  eff_w = OUTW_W'(IN_W);
        else                                 eff_w = cfg_out_w;
        lim = $signed((PRE_W'(1) << (eff_w - OUTW_W'(1))) - PRE_W'(1));
    end

    assign lane_x[0] = in_i;
    assign lane_x[1] = in_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        agc_scaler u_sc (
            .x(lane_x[l]), .mant(mant), .shamt(shamt), .lim(lim),
            .mode(cfg_mode), .post(lane_post[l]), .meas(lane_meas[l])
        );
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            meas_i    <= '0;
            meas_q    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i  <= lane_post[0];
                out_q  <= lane_post[1];
                meas_i <= lane_meas[0];
                meas_q <= lane_meas[1];
            end
        end
    end
endmodule

// File: rtl/agc_log_loop_chk.sv
// Property checker for agc_log_loop, bound into every instance.
module agc_log_loop_chk
    import agc_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_bypass,
    input logic                    cfg_mode,
    input logic signed [G_W-1:0]   cfg_fix_gain,
    input logic [OUTW_W-1:0]       cfg_out_w,
    input logic                    pwr_stb,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [IN_W-1:0]  out_i,
    input logic signed [PRE_W-1:0] meas_i,
    input logic signed [G_W-1:0]   gain_log
);
    logic                    mode_q;
    logic [OUTW_W-1:0]       w_q;
    logic [OUTW_W-1:0]       w_eff;
    logic signed [PRE_W-1:0] lim_q;
    logic signed [PRE_W-1:0] out_ext;

    // Configuration that applied to the sample now at the output.
    always_ff @(posedge clk) begin
        mode_q <= cfg_mode;
        w_q    <= cfg_out_w;
    end

    // Limit seen by the output sample.
    always_comb begin
        w_eff   = (w_q < OUTW_W'(2)) ? OUTW_W'(2) : ((w_q > OUTW_W'(IN_W)) ? OUTW_W'(IN_W) : w_q);
        lim_q   = $signed((PRE_W'(1) << (w_eff - OUTW_W'(1))) - PRE_W'(1));
        out_ext = PRE_W'(out_i);
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && gain_log == '0));

    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r4_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_stb && !cfg_bypass) |=> $stable(gain_log));

    a_r10_bypass_pin: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bypass |=> gain_log == $past(cfg_fix_gain));

    a_r7_clip_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_ext <= lim_q && out_ext >= -lim_q));

    a_r8_level_meas: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !mode_q && meas_i <= lim_q && meas_i >= -lim_q) |-> out_ext == meas_i);

    a_r9_residue_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mode_q && out_ext < lim_q && out_ext > -lim_q) |-> meas_i == '0);
endmodule

bind agc_log_loop agc_log_loop_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_mode(cfg_mode),
    .cfg_fix_gain(cfg_fix_gain), .cfg_out_w(cfg_out_w), .pwr_stb(pwr_stb),
    .in_valid(in_valid), .out_valid(out_valid), .out_i(out_i), .meas_i(meas_i),
    .gain_log(gain_log)
);

// File: tb/agc_log_loop_test.sv
`timescale 1ns/1ps
module agc_log_loop_test;
    import agc_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_bypass = 1'b0, cfg_mode = 1'b0;
    logic signed [G_W-1:0] cfg_fix_gain = '0;
    logic [LOG_W-1:0] cfg_req = '0;
    logic [K_W-1:0] cfg_k = '0;
    logic [P_W-1:0] cfg_p = '0;
    logic [OUTW_W-1:0] cfg_out_w = 5'd16;
    logic pwr_stb = 1'b0;
    logic [PWR_W-1:0] pwr_val = '0;
    logic in_valid = 1'b0;
    logic signed [IN_W-1:0] in_i = '0, in_q = '0;
    logic out_valid;
    logic signed [IN_W-1:0] out_i, out_q;
    logic signed [PRE_W-1:0] meas_i, meas_q;
    logic signed [G_W-1:0] gain_log;

    always #2.5 clk = ~clk;

    agc_log_loop uut (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // model state
    longint my = 0, md = 0, me = 0;
    longint mK = 0, mP = 0, mR = 0;
    int mw = 16;
    bit mmode = 0, mbyp = 0;

    longint q_oi[$], q_oq[$], q_mi[$], q_mq[$];
    string  q_tag[$];

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint mlog2(input longint p);
        int m = 0;
        longint fr;
        if (p == 0) return 0;
        for (int b = 0; b < 32; b++) if (((p >> b) & 1) != 0) m = b;
        if (m >= 8) fr = (p >> (m - 8)) & 255;
        else        fr = (p << (8 - m)) & 255;
        return longint'(m) * 256 + fr;
    endfunction

    function automatic void model_out(input longint x, output longint post, output longint meas);
        longint yi, mant, pre, lim;
        int idx, ew;
        yi   = my >>> 8;
        idx  = int'((my >> 4) & 15);
        mant = longint'($rtoi(256.0 * (2.0 ** (real'(idx) / 16.0)) + 0.5));
        pre  = (x * mant) >>> (8 - yi);
        ew   = (mw < 2) ? 2 : ((mw > 16) ? 16 : mw);
        lim  = (longint'(1) << (ew - 1)) - 1;
        post = (pre > lim) ? lim : ((pre < -lim) ? -lim : pre);
        meas = mmode ? (pre - post) : pre;
    endfunction

    function automatic void model_strobe(input longint pw);
        longint acc, ys;
        if (mbyp) return;
        acc = mP * md + mK * me;
        md  = acc >>> 8;
        ys  = my + md;
        my  = (ys > 2047) ? 2047 : ((ys < -2048) ? -2048 : ys);
        me  = mR - (mlog2(pw) >> 1);
    endfunction

    task automatic push_exp(input longint xi, input longint xq, input string tag);
        longint pi, mi, pq, mq;
        model_out(xi, pi, mi);
        model_out(xq, pq, mq);
        q_oi.push_back(pi); q_mi.push_back(mi);
        q_oq.push_back(pq); q_mq.push_back(mq);
        q_tag.push_back(tag);
    endtask

    // driver: one sample
    task automatic send(input longint xi, input longint xq, input string tag);
        push_exp(xi, xq, tag);
        in_valid = 1'b1; in_i = IN_W'(xi); in_q = IN_W'(xq);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // driver: one power strobe, then compare the gain
    task automatic strobe(input longint pw, input string tag);
        model_strobe(pw);
        pwr_stb = 1'b1; pwr_val = PWR_W'(pw);
        @(negedge clk);
        pwr_stb = 1'b0;
        chk(tag, longint'(gain_log), my);
    endtask

    // strobe and sample in the same cycle
    task automatic both(input longint xi, input longint xq, input longint pw, input string tag);
        push_exp(xi, xq, tag);
        model_strobe(pw);
        pwr_stb = 1'b1; pwr_val = PWR_W'(pw);
        in_valid = 1'b1; in_i = IN_W'(xi); in_q = IN_W'(xq);
        @(negedge clk);
        pwr_stb = 1'b0; in_valid = 1'b0;
        chk({tag, " gain"}, longint'(gain_log), my);
    endtask

    task automatic set_cfg(input bit byp, input bit mode, input longint fix, input longint req,
                           input longint k, input longint p, input int w);
        repeat (2) @(negedge clk);
        cfg_bypass = byp; cfg_mode = mode; cfg_fix_gain = G_W'(fix);
        cfg_req = LOG_W'(req); cfg_k = K_W'(k); cfg_p = P_W'(p); cfg_out_w = OUTW_W'(w);
        mbyp = byp; mmode = mode; mR = req; mK = k; mP = p; mw = w;
        if (byp) begin my = fix; md = 0; me = 0; end
        @(negedge clk);
    endtask

    // monitor: compare every produced sample with the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (q_oi.size() == 0) begin
                chk("R6 unexpected out_valid", 1, 0);
            end else begin
                string t;
                t = q_tag.pop_front();
                chk({t, " out_i"}, longint'(out_i), q_oi.pop_front());
                chk({t, " out_q"}, longint'(out_q), q_oq.pop_front());
                chk({t, " meas_i"}, longint'(meas_i), q_mi.pop_front());
                chk({t, " meas_q"}, longint'(meas_q), q_mq.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", longint'(out_valid), 0);
        chk("R1 gain in reset", longint'(gain_log), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", longint'(out_valid), 0);
        chk("R1 gain after reset", longint'(gain_log), 0);

        // unity gain, full width; R7 symmetric clip of -32768
        set_cfg(0, 0, 0, 2816, 256, 0, 16);
        send(100, -200, "R6 unity");
        send(32767, -32768, "R7 symmetric full width");

        // R2 log/error and delayed effect, R3 first step
        strobe(longint'(1) << 20, "R3 first strobe keeps gain");
        strobe(longint'(1) << 20, "R2 log error step");
        chk("R2 gain value", longint'(gain_log), 256);
        repeat (6) @(negedge clk);
        chk("R4 gain holds", longint'(gain_log), my);
        send(1000, -3, "R6 gain two");

        // R3 pole in use, varied powers incl. zero and fractional log
        set_cfg(0, 0, 0, 2600, 300, 128, 16);
        strobe(1 << 10, "R3 pole step a");
        strobe(longint'(1) << 24, "R3 pole step b");
        strobe(3000, "R2 fractional log");
        strobe(0, "R2 zero power");
        strobe(77777, "R3 pole step c");
        send(1234, -4321, "R6 fractional gain");

        // same-cycle strobe and sample: old gain applies
        both(500, -700, 123456, "R6 same-cycle");
        send(500, -700, "R6 after update");

        // R5 saturation high then low
        set_cfg(0, 0, 0, 8191, 4095, 0, 16);
        strobe(1, "R5 high a");
        strobe(1, "R5 high b");
        chk("R5 top", longint'(gain_log), 2047);
        send(100, -50, "R5 max gain sample");
        send(1000, -1000, "R7 clip at max gain");
        set_cfg(0, 0, 0, 0, 4095, 0, 16);
        strobe(longint'(32'hFFFF_FFFF), "R5 low a");
        strobe(longint'(32'hFFFF_FFFF), "R5 low b");
        chk("R5 bottom", longint'(gain_log), -2048);
        send(-1000, 1000, "R5 min gain sample");

        // R10 bypass with fixed gain
        set_cfg(1, 0, 128, 0, 4095, 0, 16);
        chk("R10 pinned", longint'(gain_log), 128);
        strobe(longint'(1) << 30, "R10 strobe ignored");
        send(256, -256, "R10 fixed gain");
        set_cfg(1, 0, 128, 0, 4095, 0, 8);
        send(1000, 20, "R10 clip in bypass");

        // R8 / R9 measurement source at unity gain, width 8
        set_cfg(1, 0, 0, 0, 0, 0, 8);
        set_cfg(0, 1, 0, 0, 0, 0, 8);
        send(300, -300, "R9 residue");
        send(50, -50, "R9 no residue");
        set_cfg(0, 0, 0, 0, 0, 0, 8);
        send(300, -300, "R8 pre-clip");

        // R7 width forcing
        set_cfg(0, 0, 0, 0, 0, 0, 1);
        send(5, -5, "R7 width floor");
        set_cfg(0, 0, 0, 0, 0, 0, 20);
        send(32767, -32768, "R7 width ceiling");

        repeat (4) @(negedge clk);
        chk("R6 scoreboard drained", longint'(q_oi.size()), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule